// File: doc/BRIEF.md
# Multi-tap pixel order restorer

A split linear image sensor reads its line through four taps at once. Odd-numbered pixels leave on taps A and C, even-numbered pixels on taps B and D. Taps A and B hold the first half of the line and deliver it from pixel 1 towards the centre. Taps C and D hold the second half and deliver it from the last pixel back towards the centre. Every tap delivers a fixed number of non-image elements before its first useful sample. This block takes the four digitized tap streams and rebuilds one stream of pixels in spatial order, 1 to N.

Each tap's useful samples are written into a line buffer. The write address depends on the tap and on the sample's arrival index. The buffer is split into four lanes by address modulo 4, so the four samples of one pixel period always land in four different lanes. Because the second half arrives in reverse order, the whole line has to be stored before in-order output can begin. The buffer therefore has two banks: one line can be written while the previous one is streamed out over a valid/ready interface with start-of-line and end-of-line markers. A two-tap mode is also supported. In that mode taps A and B carry the complete odd and even sequences in ascending order.

Top module: `pxr_order_top`

## Requirements
- R1: In four-tap mode (`mode_dual`=0), after the prescan, useful beat k (counted from 0) carries pixel 2k+1 on tap A, 2k+2 on tap B, N-1-2k on tap C and N-2k on tap D. The line is then output as pixels 1..N in ascending order, one pixel per accepted transfer, with no gap between transfers inside the line while `out_ready` is held high.
- R2: In two-tap mode (`mode_dual`=1), useful beat k carries pixel 2k+1 on tap A and 2k+2 on tap B. Taps C and D are ignored, and the line is output in the same ascending order. The mode is sampled with `line_start` and holds for the whole line.
- R3: Every tap delivers PRESCAN non-image beats in four-tap mode, and 2·PRESCAN in two-tap mode, before its first useful beat. These beats never reach the output.
- R4: `out_sol` is high only with pixel 1 and `out_eol` only with pixel N. After the transfer that carries `out_eol`, the next valid pixel carries `out_sol`.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_sol` and `out_eol` stay unchanged in the next cycle.
- R6: A new line can be written into the free bank while the other bank is being read out. Both lines come out intact and in arrival order, even when the write of the new line completes in the same cycle that the last pixel of the old line is accepted.
- R7: A `line_start` that arrives while both banks hold unread lines raises `line_drop` for exactly the following cycle. The samples of that line never appear at the output, and the buffered lines are output unchanged.
- R8: While reset is asserted and in the cycle after it, `out_valid` and `line_drop` are low.
- R9: Cycles with `tap_vld` low do not advance the arrival index. Beats that arrive after a line has been completely written, and before the next `line_start`, are ignored.
- R10: A `line_start` during a partly written line restarts that line in the same bank. Only the restarted line is output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | One-cycle marker before the first beat of a line |
| mode_dual | input | 1 | 0 = four taps, 1 = two taps; sampled with line_start |
| tap_vld | input | 1 | One beat on all taps this cycle |
| tap_a | input | DW | Tap A sample (odd pixels, first half or all) |
| tap_b | input | DW | Tap B sample (even pixels, first half or all) |
| tap_c | input | DW | Tap C sample (odd pixels, second half, descending) |
| tap_d | input | DW | Tap D sample (even pixels, second half, descending) |
| out_valid | output | 1 | Output pixel available |
| out_ready | input | 1 | Consumer accepts the output pixel |
| out_data | output | DW | Pixel sample in spatial order |
| out_sol | output | 1 | Marks pixel 1 |
| out_eol | output | 1 | Marks pixel N |
| line_drop | output | 1 | One-cycle pulse: a line was refused because no bank was free |

## Verification
The write side and the read side share the bank flags. The two can collide when a line's last useful beat is written in the same cycle that the last pixel of the other bank is accepted: one bank becomes full and the other becomes empty at the same edge. The bench provokes this by delaying the second line's `line_start` so that its final beat lines up exactly with the sixteenth continuous output transfer. It judges the result by both lines emerging complete, in order and with correct markers, with no `line_drop`. A separate case fills both banks and then starts a third line, to confirm that the refusal leaves the buffered lines untouched.

// File: rtl/pxr_pkg.sv
package pxr_pkg;

    localparam int NTAP = 4;

    typedef enum logic {
        MODE_QUAD = 1'b0,
        MODE_DUAL = 1'b1
    } tap_mode_e;

    typedef struct packed {
        logic sol;
        logic eol;
    } edge_flags_t;

    // Line-buffer address (pixel number minus one) of useful sample k on a tap.
    function automatic int tap_addr(tap_mode_e m, int tap, int k, int n);
        int a;
        a = 0;
        case (tap)
            0: a = 2 * k;
            1: a = 2 * k + 1;
            2: a = (m == MODE_QUAD) ? (n - 2 - 2 * k) : 0;
            default: a = (m == MODE_QUAD) ? (n - 1 - 2 * k) : 0;
        endcase
        return a;
    endfunction

    function automatic logic tap_used(tap_mode_e m, int tap);
        return (m == MODE_QUAD) || (tap < 2);
    endfunction

    function automatic int skip_len(tap_mode_e m, int pre);
        return (m == MODE_QUAD) ? pre : 2 * pre;
    endfunction

    function automatic int last_k(tap_mode_e m, int n);
        return (m == MODE_QUAD) ? (n / 4 - 1) : (n / 2 - 1);
    endfunction

endpackage

// File: rtl/pxr_lane_ram.sv
module pxr_lane_ram #(
    parameter int DW    = 12,
    parameter int AW_L  = 4,
    localparam int DEPTH = 2 ** AW_L
) (
    input  logic            clk,
    input  logic            we,
    input  logic [AW_L-1:0] waddr,
    input  logic [DW-1:0]   wdata,
    input  logic [AW_L-1:0] raddr,
    output logic [DW-1:0]   rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/pxr_addr_gen.sv
module pxr_addr_gen
    import pxr_pkg::*;
#(
    parameter int N   = 48,
    parameter int PRE = 43,
    parameter int DW  = 12,
    localparam int AW  = $clog2(N),
    localparam int LAW = AW - 1,
    localparam int BW  = $clog2(2 * PRE + N / 2 + 1)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       line_start,
    input  tap_mode_e                  mode_in,
    input  logic                       tap_vld,
    input  logic [NTAP-1:0][DW-1:0]    tap_data,
    input  logic                       full_w,
    input  logic                       wbank,
    output logic [NTAP-1:0]            lane_we,
    output logic [NTAP-1:0][LAW-1:0]   lane_addr,
    output logic [NTAP-1:0][DW-1:0]    lane_data,
    output logic                       wr_done,
    output logic                       line_drop
);
    logic                     writing;
    tap_mode_e                mode_q;
    logic [BW-1:0]            beat;
    logic                     fire;
    int                       kidx;
    int                       skip;
    logic [NTAP-1:0][AW-1:0]  taddr;

    always_comb begin
        skip    = skip_len(mode_q, PRE);
        kidx    = int'(beat) - skip;
        fire    = writing && tap_vld && !line_start && (int'(beat) >= skip);
        wr_done = fire && (kidx == last_k(mode_q, N));
        for (int t = 0; t < NTAP; t++) begin
            taddr[t] = AW'(tap_addr(mode_q, t, kidx, N));
        end
        for (int l = 0; l < NTAP; l++) begin
            lane_we[l]   = 1'b0;
            lane_addr[l] = '0;
            lane_data[l] = '0;
            for (int t = 0; t < NTAP; t++) begin
                if (fire && tap_used(mode_q, t) && (taddr[t][1:0] == 2'(l))) begin
                    lane_we[l]   = 1'b1;
                    lane_addr[l] = {wbank, taddr[t][AW-1:2]};
                    lane_data[l] = tap_data[t];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            writing   <= 1'b0;
            mode_q    <= MODE_QUAD;
            beat      <= '0;
            line_drop <= 1'b0;
        end else begin
            line_drop <= 1'b0;
            if (line_start) begin
                if (!full_w) begin
                    writing <= 1'b1;
                    mode_q  <= mode_in;
                    beat    <= '0;
                end else begin
                    writing   <= 1'b0;
                    line_drop <= 1'b1;
                end
            end else if (writing && tap_vld) begin
                if (wr_done) writing <= 1'b0;
                else         beat    <= beat + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pxr_bank_ctl.sv
module pxr_bank_ctl (
    input  logic clk,
    input  logic rst,
    input  logic wr_done,
    input  logic rd_done,
    output logic wbank,
    output logic rbank,
    output logic full_w,
    output logic full_r
);
    logic [1:0] full_q;
    logic [1:0] full_n;

    always_comb begin
        full_n = full_q;
        if (wr_done) full_n[wbank] = 1'b1;
        if (rd_done) full_n[rbank] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= '0;
            wbank  <= 1'b0;
            rbank  <= 1'b0;
        end else begin
            full_q <= full_n;
            if (wr_done) wbank <= ~wbank;
            if (rd_done) rbank <= ~rbank;
        end
    end

    assign full_w = full_q[wbank];
    assign full_r = full_q[rbank];
endmodule

// File: rtl/pxr_rd_stream.sv
module pxr_rd_stream
    import pxr_pkg::*;
#(
    parameter int N = 48,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          full_r,
    input  logic          out_ready,
    output logic          out_valid,
    output edge_flags_t   flags,
    output logic [AW-1:0] rd_addr,
    output logic          rd_done
);
    logic [AW-1:0] ptr;

    assign out_valid = full_r;
    assign flags.sol = (ptr == '0);
    assign flags.eol = (ptr == AW'(N - 1));
    assign rd_done   = full_r && out_ready && flags.eol;
    assign rd_addr   = ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (full_r && out_ready) begin
            ptr <= flags.eol ? '0 : ptr + 1'b1;
        end
    end
endmodule

// File: rtl/pxr_order_top.sv
module pxr_order_top
    import pxr_pkg::*;
#(
    parameter int N   = 48,
    parameter int PRE = 43,
    parameter int DW  = 12,
    localparam int AW  = $clog2(N),
    localparam int LAW = AW - 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          line_start,
    input  logic          mode_dual,
    input  logic          tap_vld,
    input  logic [DW-1:0] tap_a,
    input  logic [DW-1:0] tap_b,
    input  logic [DW-1:0] tap_c,
    input  logic [DW-1:0] tap_d,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_data,
    output logic          out_sol,
    output logic          out_eol,
    output logic          line_drop
);
    logic [NTAP-1:0]          lane_we;
    logic [NTAP-1:0][LAW-1:0] lane_waddr;
    logic [NTAP-1:0][DW-1:0]  lane_wdata;
    logic [NTAP-1:0][DW-1:0]  lane_rdata;
    logic                     wr_done, rd_done;
    logic                     wbank, rbank, full_w, full_r;
    logic [AW-1:0]            rd_addr;
    edge_flags_t              flags;

    pxr_addr_gen #(.N(N), .PRE(PRE), .DW(DW)) u_wr (
        .clk       (clk),
        .rst       (rst),
        .line_start(line_start),
        .mode_in   (tap_mode_e'(mode_dual)),
        .tap_vld   (tap_vld),
        .tap_data  ({tap_d, tap_c, tap_b, tap_a}),
        .full_w    (full_w),
        .wbank     (wbank),
        .lane_we   (lane_we),
        .lane_addr (lane_waddr),
        .lane_data (lane_wdata),
        .wr_done   (wr_done),
        .line_drop (line_drop)
    );

    pxr_bank_ctl u_bank (
        .clk    (clk),
        .rst    (rst),
        .wr_done(wr_done),
        .rd_done(rd_done),
        .wbank  (wbank),
        .rbank  (rbank),
        .full_w (full_w),
        .full_r (full_r)
    );

    pxr_rd_stream #(.N(N)) u_rd (
        .clk      (clk),
        .rst      (rst),
        .full_r   (full_r),
        .out_ready(out_ready),
        .out_valid(out_valid),
        .flags    (flags),
        .rd_addr  (rd_addr),
        .rd_done  (rd_done)
    );

    for (genvar l = 0; l < NTAP; l++) begin : g_lane
        pxr_lane_ram #(.DW(DW), .AW_L(LAW)) u_ram (
            .clk  (clk),
            .we   (lane_we[l]),
            .waddr(lane_waddr[l]),
            .wdata(lane_wdata[l]),
            .raddr({rbank, rd_addr[AW-1:2]}),
            .rdata(lane_rdata[l])
        );
    end

    assign out_data = lane_rdata[rd_addr[1:0]];
    assign out_sol  = flags.sol;
    assign out_eol  = flags.eol;
endmodule

// File: rtl/pxr_order_chk.sv
module pxr_order_chk #(
    parameter int DW = 12
) (
    input logic          clk,
    input logic          rst,
    input logic          line_start,
    input logic          out_valid,
    input logic          out_ready,
    input logic [DW-1:0] out_data,
    input logic          out_sol,
    input logic          out_eol,
    input logic          line_drop
);
    AST_RST_QUIET: assert property (@(posedge clk)
        rst |=> (!out_valid && !line_drop)); // R8

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                       && $stable(out_sol) && $stable(out_eol))); // R5

    AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !(out_sol && out_eol)); // R4

    AST_EOL_NEXT_SOL: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_eol) |=> (!out_valid || out_sol)); // R4

    AST_LINE_CONT: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && !out_eol) |=> (out_valid && !out_sol)); // R1

    AST_DROP_CAUSE: assert property (@(posedge clk) disable iff (rst)
        line_drop |-> $past(line_start)); // R7
endmodule

bind pxr_order_top pxr_order_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .line_start(line_start),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_sol   (out_sol),
    .out_eol   (out_eol),
    .line_drop (line_drop)
);

// File: tb/sim_pxr_order_top.sv
module sim_pxr_order_top;
    localparam int CLK_P = 10;
    localparam int N     = 16;
    localparam int PRE   = 3;
    localparam int DW    = 12;

    // columns: mode (0 quad, 1 dual), seed, input gaps, ready pattern
    localparam int TBL [5][4] = '{
        '{0, 21, 0, 0},
        '{0, 22, 1, 1},
        '{1, 23, 0, 0},
        '{1, 24, 1, 2},
        '{0, 25, 1, 2}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_start = 1'b0, mode_dual = 1'b0, tap_vld = 1'b0, out_ready = 1'b0;
    logic [DW-1:0] ta = '0, tb = '0, tc = '0, td = '0;
    logic out_valid, out_sol, out_eol, line_drop;
    logic [DW-1:0] out_data;
    int checks = 0;
    int fails  = 0;

    always #(CLK_P / 2) clk = ~clk;

    pxr_order_top #(.N(N), .PRE(PRE), .DW(DW)) u0 (
        .clk(clk), .rst(rst), .line_start(line_start), .mode_dual(mode_dual),
        .tap_vld(tap_vld), .tap_a(ta), .tap_b(tb), .tap_c(tc), .tap_d(td),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sol(out_sol), .out_eol(out_eol), .line_drop(line_drop)
    );

    function automatic logic [DW-1:0] pix(int s, int p);
        return DW'((s * 97 + p * 13 + 5) % 4096);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic start_line(int mode);
        @(negedge clk);
        line_start = 1'b1;
        mode_dual  = mode[0];
        @(negedge clk);
        line_start = 1'b0;
    endtask

    // Drives beats; limit < 0 means the whole line.
    task automatic send_beats(int mode, int seed, int gap, int limit);
        int skip  = mode ? 2 * PRE : PRE;
        int total = skip + (mode ? N / 2 : N / 4);
        if (limit >= 0) total = limit;
        for (int i = 0; i < total; i++) begin
            if (gap != 0 && i % 3 == 2) begin
                tap_vld = 1'b0;
                ta = 12'h111; tb = 12'h222; tc = 12'h333; td = 12'h444;
                @(negedge clk);
            end
            if (i < skip) begin
                ta = 12'hA00 ^ DW'(i); tb = 12'hB00 ^ DW'(i);
                tc = 12'hC00 ^ DW'(i); td = 12'hD00 ^ DW'(i);
            end else begin
                int k = i - skip;
                ta = pix(seed, 2 * k + 1);
                tb = pix(seed, 2 * k + 2);
                tc = mode ? 12'h555 : pix(seed, N - 1 - 2 * k);
                td = mode ? 12'h666 : pix(seed, N - 2 * k);
            end
            tap_vld = 1'b1;
            @(negedge clk);
        end
        tap_vld = 1'b0;
    endtask

    task automatic send_line(int mode, int seed, int gap);
        start_line(mode);
        send_beats(mode, seed, gap, -1);
    endtask

    // rpat: 0 always ready, 1 alternate, 2 low every third cycle
    task automatic recv_line(int seed, int rpat, string req);
        int j = 0;
        int cyc = 0;
        logic stalled = 1'b0;
        logic [DW+1:0] held = '0;
        while (j < N) begin
            @(negedge clk);
            if (stalled) begin
                chk("R5 hold valid", 32'(out_valid), 32'd1);
                chk("R5 hold data/flags", 32'({out_data, out_sol, out_eol}), 32'(held));
            end
            case (rpat)
                1:       out_ready = (cyc % 2 == 0);
                2:       out_ready = (cyc % 3 != 1);
                default: out_ready = 1'b1;
            endcase
            stalled = out_valid && !out_ready;
            held    = {out_data, out_sol, out_eol};
            if (out_valid && out_ready) begin
                chk({req, " data"}, 32'(out_data), 32'(pix(seed, j + 1)));
                chk("R4 sol", 32'(out_sol), 32'(j == 0));
                chk("R4 eol", 32'(out_eol), 32'(j == N - 1));
                j++;
            end
            cyc++;
        end
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL R1 watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R8: reset state
        repeat (3) @(negedge clk);
        chk("R8 valid in reset", 32'(out_valid), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R8 valid after reset", 32'(out_valid), 32'd0);
        chk("R8 drop after reset", 32'(line_drop), 32'd0);

        // R1, R2, R3, R9: table of line patterns
        for (int e = 0; e < 5; e++) begin
            send_line(TBL[e][0], TBL[e][1], TBL[e][2]);
            recv_line(TBL[e][1], TBL[e][3], TBL[e][0] != 0 ? "R2 R3" : "R1 R3");
        end

        // R7: both banks full, third line refused
        send_line(0, 31, 0);
        send_line(1, 32, 0);
        start_line(0);
        chk("R7 drop pulse", 32'(line_drop), 32'd1);
        send_beats(0, 33, 0, -1);
        chk("R7 drop single cycle", 32'(line_drop), 32'd0);
        recv_line(31, 0, "R7 first kept");
        recv_line(32, 1, "R7 second kept");
        @(negedge clk);
        chk("R7 dropped line absent", 32'(out_valid), 32'd0);

        // R10: restart during partial write
        start_line(0);
        send_beats(0, 41, 0, PRE + 2);
        send_line(0, 42, 1);
        recv_line(42, 2, "R10 restarted");
        @(negedge clk);
        chk("R10 no leftover line", 32'(out_valid), 32'd0);

        // R9: extra beats after a completed line
        send_line(1, 51, 0);
        send_beats(0, 52, 0, PRE + 3);
        recv_line(51, 0, "R9 extra beats ignored");
        @(negedge clk);
        chk("R9 no extra line", 32'(out_valid), 32'd0);

        // R6: write completion coincides with last read transfer
        send_line(0, 61, 0);
        fork
            begin
                repeat (8) @(negedge clk);
                send_line(0, 62, 0);
            end
            recv_line(61, 0, "R6 old line");
        join
        chk("R6 no drop", 32'(line_drop), 32'd0);
        recv_line(62, 1, "R6 new line");
        @(negedge clk);
        chk("R6 banks drained", 32'(out_valid), 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule